// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

This block is a serial convolutional encoder of rate one half and constraint length three. Message bits arrive one per clock over a valid/ready handshake, the most significant bit of the message first. Every accepted bit yields one registered two-bit code symbol on the following cycle. Each symbol is computed from the incoming bit and a two-stage history register, using the fixed generator pair 111 and 101.

The caller flags the final bit of a message. The block then drops its ready output and feeds two zero bits through the encoder without further input. This returns the history register to the all-zero state, so the next message starts from a known state.

A single-cycle completion pulse coincides with the last flushing symbol. Message bits offered during the flush are not taken.

Top module: `conv_half_enc`

## Requirements
- R1: While reset is high and on the first cycle after it, sym_valid and done are low and in_ready is high; both history stages are zero, so the first symbol after reset depends only on the first message bit.
- R2: sym_out[1] equals the XOR of the coded bit, the newer history stage D and the older history stage D2 (generator 111).
- R3: sym_out[0] equals the XOR of the coded bit and the older history stage D2 (generator 101).
- R4: A bit taken on a clock edge where in_valid and in_ready are both high produces exactly one symbol, with sym_valid high, after that edge; after each step the coded bit becomes D and the old D becomes D2.
- R5: Bits are encoded in arrival order, most significant message bit first; the message 1111010 yields the data symbols 11 01 10 10 01 00 10 in that order.
- R6: After the bit flagged with in_last, two more symbols are emitted by encoding zero bits back to back with sym_valid held high; the history is zero afterwards, and for the message 1111010 these symbols are 11 then 00.
- R7: in_ready is low on the two cycles after the last message bit is taken, and a bit offered then is not encoded: the flush symbols and the next message's symbols are unaffected.
- R8: done is high for exactly one cycle, on the cycle the second flush symbol is presented, and in_ready is high again on that cycle.
- R9: A new message taken straight after done is encoded from the all-zero history.
- R10: On cycles where in_ready is high and in_valid is low, no symbol is produced on the next cycle and the history is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Message bit |
| in_valid | input | 1 | in_bit holds a message bit |
| in_last | input | 1 | in_bit is the final bit of the message |
| in_ready | output | 1 | Block can take a bit this cycle |
| sym_out | output | 2 | Code symbol; bit 1 from generator 111, bit 0 from generator 101 |
| sym_valid | output | 1 | sym_out is valid this cycle |
| done | output | 1 | One-cycle pulse with the final flush symbol |

## Verification
The bench builds the encoder with the package default constraint length of three, so the history has two stages, the trellis has four states, and each flush is two cycles long. With so few states, short messages of all ones, alternating bits, a single bit, and the worked seven-bit example visit every state and every transition, including those into the flush. Back-to-back messages, idle gaps between bits, and a reset in the middle of a message bring the ready handshake, the ignored offers during the flush, and the return to the zero state within reach of the port-level scoreboard.

// File: rtl/conv_half_pkg.sv
package conv_half_pkg;

    localparam int CONSTR_LEN = 3;
    localparam int MEM_LEN    = CONSTR_LEN - 1;
    localparam int NUM_OUT    = 2;

    // tap masks over the window {coded bit, D, D2}, coded bit at the MSB
    localparam logic [CONSTR_LEN-1:0] GEN_HI = 3'b111;
    localparam logic [CONSTR_LEN-1:0] GEN_LO = 3'b101;

    typedef enum logic {
        PH_MSG   = 1'b0,
        PH_FLUSH = 1'b1
    } phase_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } sym_t;

    // generator 0 drives the most significant symbol bit
    function automatic logic [CONSTR_LEN-1:0] gen_poly(input int idx);
        return (idx == 0) ? GEN_HI : GEN_LO;
    endfunction

    function automatic logic tap_xor(input logic [CONSTR_LEN-1:0] window,
                                     input logic [CONSTR_LEN-1:0] mask);
        return ^(window & mask);
    endfunction

endpackage

// File: rtl/conv_half_mem.sv
module conv_half_mem #(
    parameter int MEM_LEN = conv_half_pkg::MEM_LEN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               shift_in,
    output logic [MEM_LEN-1:0] mem_q
);

    // mem_q[MEM_LEN-1] is the newest stage (D), mem_q[0] the oldest
    generate
        if (MEM_LEN == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           mem_q <= '0;
                else if (shift_en) mem_q <= shift_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)           mem_q <= '0;
                else if (shift_en) mem_q <= {shift_in, mem_q[MEM_LEN-1:1]};
            end
        end
    endgenerate

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(mem_q));

    assert_newest_takes_bit_R4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (mem_q[MEM_LEN-1] == $past(shift_in)));

endmodule

// File: rtl/conv_half_symgen.sv
module conv_half_symgen
    import conv_half_pkg::*;
#(
    parameter int MEM_LEN = conv_half_pkg::MEM_LEN,
    parameter int NUM_OUT = conv_half_pkg::NUM_OUT
) (
    input  logic               code_bit,
    input  logic [MEM_LEN-1:0] mem,
    output logic [NUM_OUT-1:0] sym
);

    localparam int WIN_W = MEM_LEN + 1;

    logic [WIN_W-1:0] window;
    assign window = {code_bit, mem};

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_tap
            assign sym[NUM_OUT-1-g] = tap_xor(window, gen_poly(g));
        end
    endgenerate

endmodule

// File: rtl/conv_half_flush_ctrl.sv
module conv_half_flush_ctrl
    import conv_half_pkg::*;
#(
    parameter int MEM_LEN = conv_half_pkg::MEM_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_last,
    output logic ready,
    output logic flushing,
    output logic flush_final
);

    localparam int CNT_W = (MEM_LEN > 1) ? $clog2(MEM_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MEM_LEN - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_MSG;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_MSG: begin
                    if (take && take_last) begin
                        phase_q <= PH_FLUSH;
                        cnt_q   <= '0;
                    end
                end
                PH_FLUSH: begin
                    if (cnt_q == CNT_LAST) begin
                        phase_q <= PH_MSG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_MSG;
            endcase
        end
    end

    assign ready       = (phase_q == PH_MSG);
    assign flushing    = (phase_q == PH_FLUSH);
    assign flush_final = flushing && (cnt_q == CNT_LAST);

    assert_flush_starts_R6: assert property (@(posedge clk) disable iff (rst)
        (take && take_last) |=> flushing);

    assert_flush_ends_R8: assert property (@(posedge clk) disable iff (rst)
        flush_final |=> ready);

endmodule

// File: rtl/conv_half_enc.sv
module conv_half_enc
    import conv_half_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_bit,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [1:0] sym_out,
    output logic       sym_valid,
    output logic       done
);

    logic               take;
    logic               flushing;
    logic               flush_final;
    logic               step;
    logic               code_bit;
    logic [MEM_LEN-1:0] mem_q;
    logic [NUM_OUT-1:0] sym_next;
    sym_t               sym_q;
    logic               valid_q;
    logic               done_q;

    assign take     = in_valid && in_ready;
    assign step     = take || flushing;
    assign code_bit = flushing ? 1'b0 : in_bit;

    conv_half_flush_ctrl #(.MEM_LEN(MEM_LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .take_last  (in_last),
        .ready      (in_ready),
        .flushing   (flushing),
        .flush_final(flush_final)
    );

    conv_half_mem #(.MEM_LEN(MEM_LEN)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .shift_en(step),
        .shift_in(code_bit),
        .mem_q   (mem_q)
    );

    conv_half_symgen #(.MEM_LEN(MEM_LEN), .NUM_OUT(NUM_OUT)) u_sym (
        .code_bit(code_bit),
        .mem     (mem_q),
        .sym     (sym_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q   <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= step;
            done_q  <= flush_final;
            if (step) sym_q <= sym_t'(sym_next);
        end
    end

    assign sym_out   = {sym_q.hi, sym_q.lo};
    assign sym_valid = valid_q;
    assign done      = done_q;

    assert_symbol_follows_take_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> sym_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !sym_valid);

    assert_ready_low_flush_R7: assert property (@(posedge clk) disable iff (rst)
        (take && in_last) |=> !in_ready);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_with_symbol_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (sym_valid && in_ready));

    assert_state_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_q == '0));

endmodule

// File: tb/conv_half_enc_tb.sv
module conv_half_enc_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_bit = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [1:0] sym_out;
    logic       sym_valid;
    logic       done;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_half_enc u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_bit   (in_bit),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .sym_out  (sym_out),
        .sym_valid(sym_valid),
        .done     (done)
    );

    typedef struct {
        logic [1:0] sym;
        logic       dn;
        logic       rdy;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t got;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    logic m_d1 = 1'b0;
    logic m_d2 = 1'b0;

    function automatic logic [1:0] model_sym(input logic b, input logic d1, input logic d2);
        return {b ^ d1 ^ d2, b ^ d2};
    endfunction

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic push_step(input logic b, input logic rdy, input logic dn, input string req);
        exp_t e;
        e.sym = model_sym(b, m_d1, m_d2);
        e.dn  = dn;
        e.rdy = rdy;
        e.req = req;
        q.push_back(e);
        m_d2 = m_d1;
        m_d1 = b;
    endtask

    // drives bits MSB first; holds valid high while ready is low
    task automatic send_msg(input logic [31:0] bits, input int len, input int gap,
                            input bit with_last, input string req);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = bits[i];
            in_last  = with_last && (i == 0);
            while (!in_ready) @(negedge clk);
            push_step(bits[i], !(with_last && i == 0), 1'b0, req);
            if (with_last && i == 0) begin
                push_step(1'b0, 1'b0, 1'b0, "R6 flush 1");
                push_step(1'b0, 1'b1, 1'b1, "R6 flush 2");
            end
            @(posedge clk);
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (sym_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4", $sformatf("symbol %b with nothing expected", sym_out));
                end else begin
                    got = q.pop_front();
                    chk(sym_out == got.sym, got.req,
                        $sformatf("sym_out actual %b expected %b", sym_out, got.sym));
                    chk(done == got.dn, "R8",
                        $sformatf("done actual %b expected %b", done, got.dn));
                    chk(in_ready == got.rdy, "R7",
                        $sformatf("in_ready actual %b expected %b", in_ready, got.rdy));
                end
            end else begin
                chk(done == 1'b0, "R10",
                    $sformatf("done actual %b expected 0 with no symbol", done));
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic [13:0] ex_syms;
        logic        d1;
        logic        d2;
        logic [6:0]  ex_msg;

        // R5: bench model against the worked example
        ex_msg = 7'b1111010;
        d1 = 1'b0;
        d2 = 1'b0;
        ex_syms = '0;
        for (int i = 6; i >= 0; i--) begin
            ex_syms = {ex_syms[11:0], model_sym(ex_msg[i], d1, d2)};
            d2 = d1;
            d1 = ex_msg[i];
        end
        chk(ex_syms == 14'b11011010010010, "R5",
            $sformatf("model symbols actual %b expected %b", ex_syms, 14'b11011010010010));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!sym_valid && !done && in_ready, "R1",
            $sformatf("in reset actual v=%b d=%b r=%b expected 0 0 1", sym_valid, done, in_ready));
        rst = 1'b0;
        @(negedge clk);
        chk(!sym_valid && !done && in_ready, "R1",
            $sformatf("after reset actual v=%b d=%b r=%b expected 0 0 1", sym_valid, done, in_ready));

        // R5 R6 R2 R3: worked example, flush symbols 11 then 00
        send_msg(32'b1111010, 7, 0, 1'b1, "R5 example");
        // R7 R9: back-to-back message, offered during the flush
        send_msg(32'b1, 1, 0, 1'b1, "R9 single bit");
        send_msg(32'hFF, 8, 0, 1'b1, "R2 all ones");
        go_idle(3);

        // R10: gaps between bits
        send_msg(32'b1010110, 7, 3, 1'b1, "R10 gapped");
        go_idle(2);
        send_msg(32'b0101, 4, 0, 1'b1, "R3 alternating");
        send_msg(32'b100100111, 9, 1, 1'b1, "R4 mixed");
        go_idle(4);

        // R1: reset in the middle of a message clears the history
        send_msg(32'b111, 3, 0, 1'b0, "R1 partial");
        go_idle(3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sym_valid && !done && in_ready, "R1",
            $sformatf("mid reset actual v=%b d=%b r=%b expected 0 0 1", sym_valid, done, in_ready));
        m_d1 = 1'b0;
        m_d2 = 1'b0;
        rst = 1'b0;
        send_msg(32'b0110, 4, 0, 1'b1, "R1 after reset");
        go_idle(6);

        chk(q.size() == 0, "R4",
            $sformatf("pending symbols actual %0d expected 0", q.size()));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule